// File: doc/BRIEF.md
# Write-Back Three-State Snooping Cache Controller

This block is the coherence engine of one node in a small shared-bus multiprocessor. It manages a direct-mapped, write-back cache where each line is Invalid, Shared (clean, readable) or Exclusive (the sole copy, dirty and writable). The processor holds a request until the block reports completion. Hits complete at once. Misses are turned into bus requests, and the cache is refilled from the data the bus returns.

The block also watches the misses that other nodes place on the bus and compares them against its own tags. When it holds the requested line dirty, it hands the line over and tells the memory side to drop its own answer. Otherwise it drops or keeps its copy as the protocol requires. A granted bus transaction is atomic: the grant, the snoops at every other node and the refill in the following cycle finish before the next grant.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address places a bus request and no snoop is answered with an abort.
- R2: A processor read to a line that is not present places a read miss (bus op code 1) at the request address. It completes in the refill cycle with the refill data. Later reads of that address complete with no bus request.
- R3: A processor write to a line that is not present places a write miss (op code 2) and leaves the line Exclusive. Later reads and writes to it complete with no bus request.
- R4: A processor write to a Shared line places a write miss and then holds the line Exclusive.
- R5: A miss whose index holds a different, Exclusive tag first places a write-back (op code 3) carrying the old address and its dirty data. Only after that is granted does the block place the miss.
- R6: A miss whose index holds a different, Shared tag places only the miss, with no write-back.
- R7: A snooped read miss (snoop write flag 0) that hits an Exclusive line raises the abort output in the same cycle, with the line's data on the snoop data output. The line becomes Shared, so a later local write needs a write miss.
- R8: A snooped write miss (snoop write flag 1) that hits an Exclusive line raises the abort with the line's data, and the line becomes Invalid.
- R9: A snooped write miss that hits a Shared line makes it Invalid without an abort.
- R10: A snooped read miss that hits a Shared line, or any snoop whose tag differs, leaves the line unchanged and raises no abort.
- R11: A snoop that hits a valid line takes the cycle. A processor request in that cycle does not complete and is served later.
- R12: With several nodes on one bus, every read returns the value of the most recent completed write to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_done |
| cpu_done | output | 1 | Request completes at this clock edge |
| bus_req | output | 1 | Bus request, held until bus_gnt |
| bus_op | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of the bus request |
| bus_wdata | output | DATA_W | Dirty data carried by a write-back |
| bus_gnt | input | 1 | Grant; the request is consumed this cycle |
| fill_valid | input | 1 | Refill data for the outstanding miss |
| fill_data | input | DATA_W | Refill data |
| snp_valid | input | 1 | A remote miss is on the bus |
| snp_wr | input | 1 | 1 = remote write miss, 0 = remote read miss |
| snp_addr | input | ADDR_W | Address of the remote miss |
| snp_abort | output | 1 | This node supplies the data; memory must not answer |
| snp_data | output | DATA_W | Dirty data supplied with snp_abort |

## Verification
A hit completes in the cycle in which the request is seen. A clean miss issues its request one cycle later and completes two cycles after the grant cycle's predecessor, in the refill cycle. A dirty replacement adds one write-back cycle ahead of the miss. The abort and the supplied data are combinational in the snoop cycle. The bench's bus model drives grants and snoops just after the falling edge and samples the abort, the snoop data and the snooped node's completion flag two nanoseconds later. Processor tasks raise requests one nanosecond after the falling edge and sample completion three nanoseconds after it, so every value is read while it is settled and before the rising edge that commits it.

// File: rtl/msi_pkg.sv
package msi_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHD = 2'd1,
      LS_EXC = 2'd2
   } line_st_e;

   typedef enum logic [1:0] {
      BOP_NONE   = 2'd0,
      BOP_RDMISS = 2'd1,
      BOP_WRMISS = 2'd2,
      BOP_WBACK  = 2'd3
   } bus_op_e;

   typedef enum logic [1:0] {
      CF_IDLE,
      CF_EVICT,
      CF_MISS,
      CF_FILL
   } ctl_st_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
   import msi_pkg::*;
#(
   parameter int IDX_W      = 2,
   parameter int TAG_W      = 6,
   parameter int DATA_W     = 16,
   parameter bit CLEAR_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  a_idx,
   output line_st_e          a_state,
   output logic [TAG_W-1:0]  a_tag,
   output logic [DATA_W-1:0] a_data,
   input  logic [IDX_W-1:0]  b_idx,
   output line_st_e          b_state,
   output logic [TAG_W-1:0]  b_tag,
   output logic [DATA_W-1:0] b_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  line_st_e          wr_state,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic              wr_data_en,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int LINES = 1 << IDX_W;

   line_st_e          st_q  [LINES];
   logic [TAG_W-1:0]  tag_q [LINES];
   logic [DATA_W-1:0] dat_q [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic hit_wr;
      assign hit_wr = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q[g]  <= LS_INV;
            tag_q[g] <= '0;
         end else if (hit_wr) begin
            st_q[g]  <= wr_state;
            tag_q[g] <= wr_tag;
         end
      end

      if (CLEAR_DATA) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    dat_q[g] <= '0;
            else if (hit_wr && wr_data_en) dat_q[g] <= wr_data;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit_wr && wr_data_en) dat_q[g] <= wr_data;
         end
      end
   end

   assign a_state = st_q[a_idx];
   assign a_tag   = tag_q[a_idx];
   assign a_data  = dat_q[a_idx];
   assign b_state = st_q[b_idx];
   assign b_tag   = tag_q[b_idx];
   assign b_data  = dat_q[b_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
   import msi_pkg::*;
#(
   parameter int TAG_W = 6
) (
   input  logic             snp_valid,
   input  logic             snp_wr,
   input  logic [TAG_W-1:0] snp_tag,
   input  line_st_e         line_state,
   input  logic [TAG_W-1:0] line_tag,
   output logic             hit,
   output logic             abort,
   output logic             upd_en,
   output line_st_e         upd_state
);
   always_comb begin
      hit       = snp_valid && (line_state != LS_INV) && (line_tag == snp_tag);
      abort     = hit && (line_state == LS_EXC);
      upd_en    = 1'b0;
      upd_state = line_state;
      if (abort) begin
         upd_en    = 1'b1;
         upd_state = snp_wr ? LS_INV : LS_SHD;
      end else if (hit && snp_wr) begin
         upd_en    = 1'b1;
         upd_state = LS_INV;
      end
   end
endmodule

// File: rtl/msi_cpu_fsm.sv
module msi_cpu_fsm
   import msi_pkg::*;
#(
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [TAG_W-1:0]  cpu_tag,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   input  line_st_e          line_state,
   input  logic [TAG_W-1:0]  line_tag,
   input  logic [DATA_W-1:0] line_data,
   input  logic              snoop_busy,
   output logic              bus_req,
   output bus_op_e           bus_op,
   output logic [TAG_W-1:0]  bus_tag,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data,
   output logic              upd_en,
   output line_st_e          upd_state,
   output logic [TAG_W-1:0]  upd_tag,
   output logic              upd_data_en,
   output logic [DATA_W-1:0] upd_data
);
   ctl_st_e st_q, st_d;
   logic    tag_eq, present, dirty_victim, may_hit;

   assign tag_eq       = (line_tag == cpu_tag);
   assign present      = (line_state != LS_INV) && tag_eq;
   assign dirty_victim = (line_state == LS_EXC) && !tag_eq;
   assign may_hit      = present && (!cpu_we || line_state == LS_EXC);

   always_comb begin
      st_d        = st_q;
      cpu_done    = 1'b0;
      cpu_rdata   = line_data;
      bus_req     = 1'b0;
      bus_op      = BOP_NONE;
      bus_tag     = cpu_tag;
      bus_wdata   = line_data;
      upd_en      = 1'b0;
      upd_state   = line_state;
      upd_tag     = cpu_tag;
      upd_data_en = 1'b0;
      upd_data    = cpu_wdata;
      unique case (st_q)
         CF_IDLE: begin
            if (cpu_req && !snoop_busy) begin
               if (may_hit) begin
                  cpu_done = 1'b1;
                  if (cpu_we) begin
                     upd_en      = 1'b1;
                     upd_state   = LS_EXC;
                     upd_data_en = 1'b1;
                  end
               end else begin
                  st_d = dirty_victim ? CF_EVICT : CF_MISS;
               end
            end
         end
         CF_EVICT: begin
            if (!dirty_victim) begin
               st_d = CF_MISS;
            end else begin
               bus_req = 1'b1;
               bus_op  = BOP_WBACK;
               bus_tag = line_tag;
               if (bus_gnt && !snoop_busy) begin
                  upd_en    = 1'b1;
                  upd_state = LS_INV;
                  upd_tag   = line_tag;
                  st_d      = CF_MISS;
               end
            end
         end
         CF_MISS: begin
            bus_req = 1'b1;
            bus_op  = cpu_we ? BOP_WRMISS : BOP_RDMISS;
            if (bus_gnt) st_d = CF_FILL;
         end
         CF_FILL: begin
            cpu_rdata = fill_data;
            if (fill_valid && !snoop_busy) begin
               cpu_done    = 1'b1;
               upd_en      = 1'b1;
               upd_state   = cpu_we ? LS_EXC : LS_SHD;
               upd_data_en = 1'b1;
               upd_data    = cpu_we ? cpu_wdata : fill_data;
               st_d        = CF_IDLE;
            end
         end
         default: st_d = CF_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= CF_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
   import msi_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 16,
   parameter int IDX_W      = 2,
   parameter bit CLEAR_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_done,
   output logic              bus_req,
   output logic [1:0]        bus_op,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              snp_valid,
   input  logic              snp_wr,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_abort,
   output logic [DATA_W-1:0] snp_data
);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
      $error("msi_snoop_ctrl: IDX_W must lie in 1..ADDR_W-1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("msi_snoop_ctrl: DATA_W must be positive");
   end

   logic [IDX_W-1:0]  c_idx, s_idx;
   logic [TAG_W-1:0]  c_tag, s_tag;
   line_st_e          c_state, s_state, s_upd_state, f_upd_state;
   logic [TAG_W-1:0]  c_ltag, s_ltag, f_upd_tag, f_bus_tag;
   logic [DATA_W-1:0] c_ldata, f_upd_data;
   logic              s_hit, s_upd_en, f_upd_en, f_upd_data_en;
   bus_op_e           f_bus_op;
   logic              w_en, w_data_en;
   logic [IDX_W-1:0]  w_idx;
   line_st_e          w_state;
   logic [TAG_W-1:0]  w_tag;

   assign c_idx = cpu_addr[IDX_W-1:0];
   assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign s_idx = snp_addr[IDX_W-1:0];
   assign s_tag = snp_addr[ADDR_W-1:IDX_W];

   always_comb begin
      if (s_upd_en) begin
         w_en      = 1'b1;
         w_idx     = s_idx;
         w_state   = s_upd_state;
         w_tag     = s_ltag;
         w_data_en = 1'b0;
      end else begin
         w_en      = f_upd_en;
         w_idx     = c_idx;
         w_state   = f_upd_state;
         w_tag     = f_upd_tag;
         w_data_en = f_upd_data_en;
      end
   end

   msi_line_store #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .CLEAR_DATA(CLEAR_DATA)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .a_idx(c_idx), .a_state(c_state), .a_tag(c_ltag), .a_data(c_ldata),
      .b_idx(s_idx), .b_state(s_state), .b_tag(s_ltag), .b_data(snp_data),
      .wr_en(w_en), .wr_idx(w_idx), .wr_state(w_state), .wr_tag(w_tag),
      .wr_data_en(w_data_en), .wr_data(f_upd_data)
   );

   msi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
      .snp_valid(snp_valid), .snp_wr(snp_wr), .snp_tag(s_tag),
      .line_state(s_state), .line_tag(s_ltag),
      .hit(s_hit), .abort(snp_abort), .upd_en(s_upd_en), .upd_state(s_upd_state)
   );

   msi_cpu_fsm #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag(c_tag), .cpu_wdata(cpu_wdata),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
      .line_state(c_state), .line_tag(c_ltag), .line_data(c_ldata),
      .snoop_busy(s_hit),
      .bus_req(bus_req), .bus_op(f_bus_op), .bus_tag(f_bus_tag), .bus_wdata(bus_wdata),
      .bus_gnt(bus_gnt), .fill_valid(fill_valid), .fill_data(fill_data),
      .upd_en(f_upd_en), .upd_state(f_upd_state), .upd_tag(f_upd_tag),
      .upd_data_en(f_upd_data_en), .upd_data(f_upd_data)
   );

   assign bus_op   = f_bus_op;
   assign bus_addr = {f_bus_tag, c_idx};
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_done,
   input logic              bus_req,
   input logic [1:0]        bus_op,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_gnt,
   input logic              snp_valid,
   input logic              snp_abort
);
   p_abort_on_snoop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      snp_abort |-> snp_valid);

   p_snoop_stalls_cpu_r11: assert property (@(posedge clk) disable iff (!rst_n)
      snp_abort |-> !cpu_done);

   p_done_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> cpu_req);

   p_evict_then_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_op == 2'd3) |=> (bus_req && (bus_op == 2'd1 || bus_op == 2'd2)));

   p_miss_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt && bus_op != 2'd3) |=> (bus_req && $stable(bus_op) && $stable(bus_addr)));

   p_quiet_after_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_op != 2'd3) |=> !bus_req);
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_done(cpu_done),
   .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
   .snp_valid(snp_valid), .snp_abort(snp_abort)
);

// File: tb/tb_msi_snoop_ctrl.sv
module tb_msi_snoop_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [1:0]  c_req = '0, c_we = '0, c_done;
   logic [7:0]  c_addr [2];
   logic [15:0] c_wd [2], c_rd [2];
   logic [1:0]  b_req, b_gnt = '0, f_valid = '0, s_valid = '0, s_wr = '0, s_abort;
   logic [1:0]  b_op [2];
   logic [7:0]  b_addr [2], s_addr [2];
   logic [15:0] b_wd [2], f_data [2], s_data [2];

   msi_snoop_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(c_req[0]), .cpu_we(c_we[0]), .cpu_addr(c_addr[0]),
      .cpu_wdata(c_wd[0]), .cpu_rdata(c_rd[0]), .cpu_done(c_done[0]),
      .bus_req(b_req[0]), .bus_op(b_op[0]), .bus_addr(b_addr[0]), .bus_wdata(b_wd[0]),
      .bus_gnt(b_gnt[0]), .fill_valid(f_valid[0]), .fill_data(f_data[0]),
      .snp_valid(s_valid[0]), .snp_wr(s_wr[0]), .snp_addr(s_addr[0]),
      .snp_abort(s_abort[0]), .snp_data(s_data[0]));

   msi_snoop_ctrl dut_b (
      .clk(clk), .rst_n(rst_n), .cpu_req(c_req[1]), .cpu_we(c_we[1]), .cpu_addr(c_addr[1]),
      .cpu_wdata(c_wd[1]), .cpu_rdata(c_rd[1]), .cpu_done(c_done[1]),
      .bus_req(b_req[1]), .bus_op(b_op[1]), .bus_addr(b_addr[1]), .bus_wdata(b_wd[1]),
      .bus_gnt(b_gnt[1]), .fill_valid(f_valid[1]), .fill_data(f_data[1]),
      .snp_valid(s_valid[1]), .snp_wr(s_wr[1]), .snp_addr(s_addr[1]),
      .snp_abort(s_abort[1]), .snp_data(s_data[1]));

   logic [15:0] mem [256];
   logic [15:0] gold [256];
   int total = 0, bad = 0;

   int          log_n = 0;
   int          log_node [64];
   logic [1:0]  log_op [64];
   logic [7:0]  log_addr [64];
   logic [15:0] log_data [64];
   logic        log_abort [64], log_sreq [64], log_sdone [64];

   int rr = 0, pend = 0, pn = 0;
   logic [15:0] pd;

   // Atomic shared bus: grant, snoop the other node, refill next cycle.
   always begin
      int ch, m, e;
      @(negedge clk);
      b_gnt = '0; s_valid = '0; f_valid = '0;
      if (rst_n) begin
         if (pend != 0) begin
            f_valid[pn] = 1'b1; f_data[pn] = pd; pend = 0;
         end else begin
            ch = -1;
            for (int k = 0; k < 2; k++) if (ch < 0 && b_req[(rr + k) % 2]) ch = (rr + k) % 2;
            if (ch >= 0) begin
               m = 1 - ch; rr = m; e = log_n % 64;
               b_gnt[ch] = 1'b1;
               log_node[e] = ch; log_op[e] = b_op[ch]; log_addr[e] = b_addr[ch];
               log_data[e] = b_wd[ch]; log_abort[e] = 1'b0;
               log_sreq[e] = 1'b0; log_sdone[e] = 1'b0;
               log_n++;
               if (b_op[ch] == 2'd3) begin
                  mem[b_addr[ch]] = b_wd[ch];
               end else begin
                  s_valid[m] = 1'b1; s_wr[m] = (b_op[ch] == 2'd2); s_addr[m] = b_addr[ch];
                  #2;
                  log_abort[e] = s_abort[m];
                  log_sreq[e] = c_req[m];
                  log_sdone[e] = c_done[m];
                  if (s_abort[m]) begin
                     log_data[e] = s_data[m];
                     mem[b_addr[ch]] = s_data[m];
                  end
                  pend = 1; pn = ch; pd = mem[b_addr[ch]];
               end
            end
         end
      end
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cpu_go(int n, bit we, logic [7:0] a, logic [15:0] wd, output logic [15:0] rd);
      c_we[n] = we; c_addr[n] = a; c_wd[n] = wd; c_req[n] = 1'b1;
      #2;
      while (c_done[n] !== 1'b1) begin @(negedge clk); #3; end
      rd = c_rd[n];
      @(posedge clk); #1 c_req[n] = 1'b0;
      if (we) gold[a] = wd;
   endtask

   task automatic cpu_access(int n, bit we, logic [7:0] a, logic [15:0] wd, output logic [15:0] rd);
      @(negedge clk); #1;
      cpu_go(n, we, a, wd, rd);
   endtask

   task automatic log_is(string req, int e, int node, logic [1:0] op, logic [7:0] a);
      chk(req, "bus node", log_node[e], node);
      chk(req, "bus op", log_op[e], op);
      chk(req, "bus addr", log_addr[e], a);
   endtask

   task automatic t_reset();
      logic [15:0] r;
      chk("R1", "done idle", c_done, 2'b00);
      chk("R1", "bus idle", b_req, 2'b00);
      log_n = 0;
      cpu_access(0, 0, 8'h10, 0, r);
      chk("R1", "miss count", log_n, 1);
      log_is("R1", 0, 0, 2'd1, 8'h10);
      chk("R1", "no abort", log_abort[0], 0);
      chk("R2", "fill data", r, gold[8'h10]);
   endtask

   task automatic t_read_hit();
      logic [15:0] r;
      log_n = 0;
      cpu_access(0, 0, 8'h10, 0, r);
      chk("R2", "hit no bus", log_n, 0);
      chk("R2", "hit data", r, gold[8'h10]);
   endtask

   task automatic t_write_invalid();
      logic [15:0] r;
      log_n = 0;
      cpu_access(0, 1, 8'h21, 16'hA5A5, r);
      chk("R3", "miss count", log_n, 1);
      log_is("R3", 0, 0, 2'd2, 8'h21);
      cpu_access(0, 1, 8'h21, 16'h1111, r);
      cpu_access(0, 0, 8'h21, 0, r);
      chk("R3", "E hits no bus", log_n, 1);
      chk("R3", "E data", r, 16'h1111);
   endtask

   task automatic t_upgrade();
      logic [15:0] r;
      log_n = 0;
      cpu_access(0, 0, 8'h32, 0, r);
      cpu_access(0, 1, 8'h32, 16'h4444, r);
      chk("R4", "ops", log_n, 2);
      log_is("R4", 1, 0, 2'd2, 8'h32);
      cpu_access(0, 0, 8'h32, 0, r);
      chk("R4", "now exclusive", log_n, 2);
      chk("R4", "data", r, 16'h4444);
   endtask

   task automatic t_evict_dirty();
      logic [15:0] r;
      log_n = 0;
      cpu_access(0, 0, 8'h05, 0, r);
      chk("R5", "ops", log_n, 2);
      log_is("R5", 0, 0, 2'd3, 8'h21);
      chk("R5", "wb data", log_data[0], 16'h1111);
      log_is("R5", 1, 0, 2'd1, 8'h05);
      chk("R5", "read data", r, gold[8'h05]);
      cpu_access(1, 0, 8'h21, 0, r);
      chk("R5", "memory updated", r, 16'h1111);
   endtask

   task automatic t_evict_clean();
      logic [15:0] r;
      log_n = 0;
      cpu_access(0, 1, 8'h30, 16'hBEEF, r);
      chk("R6", "no write-back", log_n, 1);
      log_is("R6", 0, 0, 2'd2, 8'h30);
   endtask

   task automatic t_snoop_read_excl();
      logic [15:0] r;
      log_n = 0;
      cpu_access(1, 0, 8'h30, 0, r);
      log_is("R7", 0, 1, 2'd1, 8'h30);
      chk("R7", "abort", log_abort[0], 1);
      chk("R7", "supplied", log_data[0], 16'hBEEF);
      chk("R7", "reader data", r, 16'hBEEF);
      cpu_access(0, 1, 8'h30, 16'hCAFE, r);
      chk("R7", "shared needs miss", log_n, 2);
      log_is("R7", 1, 0, 2'd2, 8'h30);
      chk("R9", "shared no abort", log_abort[1], 0);
      cpu_access(1, 0, 8'h30, 0, r);
      chk("R9", "invalidated misses", log_n, 3);
      chk("R7", "second abort", log_abort[2], 1);
      chk("R12", "coherent", r, 16'hCAFE);
   endtask

   task automatic t_snoop_write_excl();
      logic [15:0] r;
      log_n = 0;
      cpu_access(1, 1, 8'h32, 16'h7777, r);
      log_is("R8", 0, 1, 2'd2, 8'h32);
      chk("R8", "abort", log_abort[0], 1);
      chk("R8", "supplied", log_data[0], 16'h4444);
      cpu_access(0, 0, 8'h32, 0, r);
      chk("R8", "invalid misses", log_n, 2);
      log_is("R8", 1, 0, 2'd1, 8'h32);
      chk("R8", "new data", r, 16'h7777);
   endtask

   task automatic t_snoop_no_effect();
      logic [15:0] r;
      log_n = 0;
      cpu_access(0, 0, 8'h13, 0, r);
      cpu_access(1, 0, 8'h13, 0, r);
      chk("R10", "shared read no abort", log_abort[1], 0);
      cpu_access(1, 0, 8'h07, 0, r);
      chk("R10", "other tag no abort", log_abort[2], 0);
      cpu_access(0, 0, 8'h13, 0, r);
      chk("R10", "still shared", log_n, 3);
      chk("R10", "data", r, gold[8'h13]);
      cpu_access(1, 0, 8'h13, 0, r);
      cpu_access(0, 0, 8'h13, 0, r);
      chk("R10", "kept after snoop", log_n, 4);
   endtask

   task automatic t_priority();
      logic [15:0] r0, r1;
      cpu_access(0, 1, 8'h25, 16'h2525, r0);
      log_n = 0;
      fork
         cpu_access(1, 0, 8'h25, 0, r1);
         begin
            wait (s_valid[0] === 1'b1);
            #1;
            cpu_go(0, 0, 8'h25, 0, r0);
         end
      join
      chk("R11", "abort", log_abort[0], 1);
      chk("R11", "req present", log_sreq[0], 1);
      chk("R11", "stalled", log_sdone[0], 0);
      chk("R11", "local data", r0, 16'h2525);
      chk("R11", "remote data", r1, 16'h2525);
   endtask

   task automatic t_mixed();
      logic [15:0] r;
      logic [7:0] set [4] = '{8'h40, 8'h44, 8'h81, 8'hC0};
      for (int i = 0; i < 24; i++) begin
         logic [7:0] a;
         a = set[(i * 7) % 4];
         if (i % 3 == 0) cpu_access(i % 2, 1, a, 16'h1000 + 16'(i), r);
         else begin
            cpu_access(i % 2, 0, a, 0, r);
            chk("R12", "last value", r, gold[a]);
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i] = 16'(i * 3 + 1);
         gold[i] = mem[i];
      end
      c_addr[0] = '0; c_addr[1] = '0; c_wd[0] = '0; c_wd[1] = '0;
      s_addr[0] = '0; s_addr[1] = '0; f_data[0] = '0; f_data[1] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_read_hit();
      t_write_invalid();
      t_upgrade();
      t_evict_dirty();
      t_evict_clean();
      t_snoop_read_excl();
      t_snoop_write_excl();
      t_snoop_no_effect();
      t_priority();
      t_mixed();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule